// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the serial-side logic of a byte-wide EEPROM that answers a host over a four-wire SPI link. It runs on a fabric clock, oversamples the host's serial clock and active-low select, and decodes one 8-bit instruction per select frame. The instructions are: set or clear a write-enable latch, read or write a small status byte, read the array sequentially, and write up to one page of bytes. The storage array has a depth set by parameter and is addressed with a 16-bit address, of which the low bits are used.

Write-type instructions take effect only when the host releases select on a byte boundary. A page write first fills a staging buffer. On release the buffer is copied into the array, and a busy interval of a parameterised number of clock cycles begins. During that interval only the status-read instruction is honoured, so the host polls the in-progress bit until it clears. The serial output is registered, and its enable is low whenever the block is not shifting read or status data.

Top module: `eep_spi_slave`

## Requirements
- R1: SPI modes 0 and 3 both work. `mosi` is sampled on each SCK rising edge, most significant bit first. `miso` changes only after an SCK falling edge, and holds between falling edges. SCK high and low phases each last at least 4 `clk` cycles.
- R2: `miso_oe` is 0 whenever the block is not shifting out read or status data. This includes every cycle while `cs_n` is high, from the third cycle after it rises.
- R3: Opcodes are 0x06 latch set, 0x04 latch clear, 0x05 status read, 0x01 status write, 0x03 read, 0x02 page write. Any other opcode makes the block ignore the rest of the frame: `miso_oe` stays 0 and no state changes.
- R4: The status byte holds the in-progress flag in bit 0, the write-enable latch in bit 1, and six user bits in bits 7:2. The status-write data byte sets bits 7:2, and its bits 1:0 are ignored. The status read repeats the live status in every byte of the frame.
- R5: Opcode 0x06 sets the latch and 0x04 clears it. Each takes effect only when select rises after exactly 8 SCK rising edges.
- R6: The latch is cleared by reset, by opcode 0x04, by a committed status write and by a committed page write.
- R7: A page write or a status write whose opcode arrives while the latch is clear is ignored. The array, the status bits and the in-progress flag are left unchanged.
- R8: A page write commits only if select rises on a byte boundary after at least one data byte. A status write commits only if select rises right after its data byte. Any other release aborts the instruction, leaving the array and the latch unchanged.
- R9: A read takes a 16-bit address, high byte first, and only the low log2(DEPTH) bits are used. The read then returns consecutive bytes for as long as SCK runs, wrapping from the last location to location 0.
- R10: A page write stores each data byte at the next offset within the addressed PAGE-byte page. Past the page end it wraps to offset 0 of the same page, and locations not written in the frame keep their contents.
- R11: A commit sets the in-progress flag for WRITE_CYCLES clock cycles. While the flag is set, every opcode except status read is ignored, including reads (no output) and latch set.
- R12: After reset the status byte reads 0x00 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select, synchronous to `clk` |
| sck | input | 1 | Host serial clock, synchronous to `clk` |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, registered |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |

## Verification
The bench keeps an array image, a latch and user status bits, and predicts every status and read byte from them. It goes after release timing. A stray ninth clock after the latch-set opcode must leave the latch clear, and a page write cut off mid-byte must leave both memory and latch untouched; a design that commits on any release would corrupt memory in the second case. The page-end wrap and the top-of-array wrap are read back byte by byte, so a design that carries into the next page, or that saturates at the top, returns wrong data at a known address. During the busy interval the bench issues a latch set and a read: a design that does not block them shows a set latch afterwards, or drives the output during the read.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // Per-frame decoder position
  typedef enum logic [2:0] {
    ST_OP,      // collecting the opcode byte
    ST_ADDR,    // collecting two address bytes
    ST_RD,      // streaming array data out
    ST_RDSR,    // streaming status out
    ST_WRDATA,  // collecting page data
    ST_SRDATA,  // collecting the status data byte
    ST_DONE,    // instruction complete, waiting for release
    ST_SKIP     // ignoring the rest of the frame
  } frame_st_t;
endpackage

// File: rtl/eep_link.sv
`timescale 1ns/1ps
// Registers the serial inputs and produces single-cycle edge strobes.
module eep_link (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic desel,
  output logic mosi_s
);
  logic sck_q, sck_d, cs_q, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      sck_d  <= 1'b0;
      cs_q   <= 1'b1;
      cs_d   <= 1'b1;
      mosi_s <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_d  <= sck_q;
      cs_q   <= cs_n;
      cs_d   <= cs_q;
      mosi_s <= mosi;
    end
  end

  assign sel      = ~cs_q;
  assign sck_rise = sel & sck_q & ~sck_d;
  assign sck_fall = sel & ~sck_q & sck_d;
  assign desel    = cs_q & ~cs_d;
endmodule

// File: rtl/eep_busy.sv
`timescale 1ns/1ps
// Write-cycle timer plus a sweep over the page offsets used to copy
// the staging buffer into the array while the timer runs.
module eep_busy #(
  parameter int CYCLES = 250000,
  parameter int PAGE   = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    sw_en,
  output logic [$clog2(PAGE)-1:0] sw_idx
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam int PW = $clog2(PAGE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sw_en  <= 1'b0;
      sw_idx <= '0;
    end else begin
      if (start) begin
        cnt    <= CW'(CYCLES);
        sw_en  <= 1'b1;
        sw_idx <= '0;
      end else begin
        if (cnt != '0) cnt <= cnt - CW'(1);
        if (sw_en) begin
          sw_idx <= sw_idx + PW'(1);
          if (sw_idx == PW'(PAGE - 1)) sw_en <= 1'b0;
        end
      end
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
// Simple dual-port storage: one write port, one registered read port.
module eep_array #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_spi_slave.sv
`timescale 1ns/1ps
module eep_spi_slave
  import eep_pkg::*;
#(
  parameter int DEPTH        = 1024,
  parameter int PAGE         = 128,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int GW = AW - PW;

  logic sel, sck_rise, sck_fall, desel, mosi_s;

  eep_link u_link (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .mosi     (mosi),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .desel    (desel),
    .mosi_s   (mosi_s)
  );

  frame_st_t       st;
  logic [2:0]      bit_cnt;
  logic [6:0]      sh;
  logic [7:0]      op_q, addr_hi;
  logic [5:0]      sr_new, user_q;
  logic            addr_ph, wbytes, wel_q, page_cm, start_q;
  logic [AW-1:0]   rd_ptr;
  logic [GW-1:0]   wr_page;
  logic [PW-1:0]   wr_off;
  logic [PAGE-1:0] pmask;
  logic [7:0]      pbuf [PAGE];
  logic [6:0]      out_sr;
  logic            miso_q, oe_q;

  logic            busy, sw_en;
  logic [PW-1:0]   sw_idx;
  logic            cm_we;
  logic [AW-1:0]   cm_addr;
  logic [7:0]      cm_data, mem_rdata;

  logic [7:0]  byte_in, status, ld_byte;
  logic        byte_done, at_bnd;
  logic        commit_wr, commit_sr, latch_on, latch_off;

  always_comb begin
    byte_in   = {sh, mosi_s};
    byte_done = sck_rise && (bit_cnt == 3'd7);
    at_bnd    = (bit_cnt == 3'd0);
    status    = {user_q, wel_q, busy};
    ld_byte   = (st == ST_RD) ? mem_rdata : status;
    commit_wr = desel && at_bnd && (st == ST_WRDATA) && wbytes;
    commit_sr = desel && at_bnd && (st == ST_DONE) && (op_q == OP_WRSR);
    latch_on  = desel && at_bnd && (st == ST_DONE) && (op_q == OP_WREN);
    latch_off = desel && at_bnd && (st == ST_DONE) && (op_q == OP_WRDI);
  end

  eep_busy #(.CYCLES(WRITE_CYCLES), .PAGE(PAGE)) u_busy (
    .clk    (clk),
    .rst    (rst),
    .start  (start_q),
    .busy   (busy),
    .sw_en  (sw_en),
    .sw_idx (sw_idx)
  );

  eep_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk   (clk),
    .we    (cm_we),
    .waddr (cm_addr),
    .wdata (cm_data),
    .raddr (rd_ptr),
    .rdata (mem_rdata)
  );

  // Staging buffer: no reset so it maps onto a RAM.
  always_ff @(posedge clk) begin
    if (sel && byte_done && (st == ST_WRDATA)) pbuf[wr_off] <= byte_in;
    cm_data <= pbuf[sw_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cm_we   <= 1'b0;
      cm_addr <= '0;
    end else begin
      cm_we   <= sw_en && page_cm && pmask[sw_idx];
      cm_addr <= {wr_page, sw_idx};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_OP;
      bit_cnt <= '0;
      sh      <= '0;
      op_q    <= '0;
      addr_hi <= '0;
      addr_ph <= 1'b0;
      sr_new  <= '0;
      user_q  <= '0;
      wbytes  <= 1'b0;
      wel_q   <= 1'b0;
      page_cm <= 1'b0;
      start_q <= 1'b0;
      rd_ptr  <= '0;
      wr_page <= '0;
      wr_off  <= '0;
      pmask   <= '0;
      out_sr  <= '0;
      miso_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      start_q <= commit_wr || commit_sr;
      if (commit_wr) begin
        page_cm <= 1'b1;
        wel_q   <= 1'b0;
      end
      if (commit_sr) begin
        page_cm <= 1'b0;
        wel_q   <= 1'b0;
        user_q  <= sr_new;
      end
      if (latch_on)  wel_q <= 1'b1;
      if (latch_off) wel_q <= 1'b0;

      if (!sel) begin
        st      <= ST_OP;
        bit_cnt <= '0;
        addr_ph <= 1'b0;
        oe_q    <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh      <= {sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (st == ST_DONE) st <= ST_SKIP;
          if (byte_done) begin
            case (st)
              ST_OP: begin
                op_q <= byte_in;
                if (busy && (byte_in != OP_RDSR)) begin
                  st <= ST_SKIP;
                end else begin
                  case (byte_in)
                    OP_WREN, OP_WRDI: st <= ST_DONE;
                    OP_RDSR:          st <= ST_RDSR;
                    OP_WRSR:          st <= wel_q ? ST_SRDATA : ST_SKIP;
                    OP_READ:          st <= ST_ADDR;
                    OP_WRITE: begin
                      if (wel_q) begin
                        st     <= ST_ADDR;
                        pmask  <= '0;
                        wbytes <= 1'b0;
                      end else begin
                        st <= ST_SKIP;
                      end
                    end
                    default:          st <= ST_SKIP;
                  endcase
                end
              end
              ST_ADDR: begin
                if (!addr_ph) begin
                  addr_hi <= byte_in;
                  addr_ph <= 1'b1;
                end else begin
                  rd_ptr  <= AW'({addr_hi, byte_in});
                  wr_page <= GW'({addr_hi, byte_in} >> PW);
                  wr_off  <= byte_in[PW-1:0];
                  st      <= (op_q == OP_READ) ? ST_RD : ST_WRDATA;
                end
              end
              ST_WRDATA: begin
                pmask[wr_off] <= 1'b1;
                wr_off        <= wr_off + PW'(1);
                wbytes        <= 1'b1;
              end
              ST_SRDATA: begin
                sr_new <= byte_in[7:2];
                st     <= ST_DONE;
              end
              default: ;
            endcase
          end
        end

        if (sck_fall) begin
          if (((st == ST_RD) || (st == ST_RDSR)) && at_bnd) begin
            miso_q <= ld_byte[7];
            out_sr <= ld_byte[6:0];
            oe_q   <= 1'b1;
            if (st == ST_RD) rd_ptr <= rd_ptr + AW'(1);
          end else if (oe_q) begin
            miso_q <= out_sr[6];
            out_sr <= {out_sr[5:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
endmodule

// File: rtl/eep_spi_slave_chk.sv
`timescale 1ns/1ps
module eep_spi_slave_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic miso,
  input logic miso_oe,
  input logic wel,
  input logic wip,
  input logic fall,
  input logic desel,
  input logic mem_we
);
  a_r2_hiz_deselected: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n, 2) && $past(cs_n) && cs_n) |-> !miso_oe);

  a_r1_miso_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
    (miso_oe && $past(miso_oe) && !$past(fall)) |-> $stable(miso));

  a_r5_latch_set_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(desel));

  a_r6_latch_clear_at_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> !wel);

  a_r11_array_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wip);

  a_r11_busy_spans_cycles: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |=> wip);
endmodule

bind eep_spi_slave eep_spi_slave_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .miso    (miso),
  .miso_oe (miso_oe),
  .wel     (wel_q),
  .wip     (busy),
  .fall    (sck_fall),
  .desel   (desel),
  .mem_we  (cm_we)
);

// File: tb/eep_spi_slave_bench.sv
`timescale 1ns/1ps
module eep_spi_slave_bench;
  localparam int DEPTH = 64;
  localparam int PAGE  = 16;
  localparam int WCYC  = 400;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;

  always #2.5 clk = ~clk;

  eep_spi_slave #(.DEPTH(DEPTH), .PAGE(PAGE), .WRITE_CYCLES(WCYC)) u_eep_spi_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  int compared = 0, mismatched = 0, cyc = 0, hi_cnt = 0;
  int t_last = 0, t_commit = 0;
  bit mode3 = 1'b0, oe_seen = 1'b0, done = 1'b0;

  // behavioural reference state
  logic [7:0] mdl [DEPTH];
  bit         mwel = 1'b0;
  logic [5:0] muser = 6'd0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2: per-clock comparison of the output enable while deselected
  always @(negedge clk) begin
    if (rst || !cs_n) hi_cnt = 0;
    else hi_cnt++;
    if (hi_cnt >= 3) chk(!miso_oe, "R2 oe while deselected", miso_oe, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bit(input bit b, output bit r);
    sck = 1'b0;
    mosi = b;
    wclk(4);
    r = miso;
    if (miso_oe) oe_seen = 1'b1;
    sck = 1'b1;
    wclk(4);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      bit r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic sel_on();
    sck = mode3;
    wclk(2);
    oe_seen = 1'b0;
    cs_n = 1'b0;
    wclk(4);
  endtask

  task automatic sel_off();
    if (!mode3) begin
      sck = 1'b0;
      wclk(4);
    end
    cs_n = 1'b1;
    t_last = cyc;
    wclk(6);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel_on(); spi_byte(op, d); sel_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel_on(); spi_byte(8'h05, d); spi_byte(8'h00, s); sel_off();
  endtask

  task automatic chk_status(input logic [7:0] exp, input string tag);
    logic [7:0] s;
    rdsr(s);
    chk(s === exp, tag, s, exp);
  endtask

  task automatic do_write(input int addr, input logic [7:0] q[$]);
    logic [7:0] d;
    int a, base;
    sel_on();
    spi_byte(8'h02, d); spi_byte(addr[15:8], d); spi_byte(addr[7:0], d);
    foreach (q[i]) spi_byte(q[i], d);
    sel_off();
    t_commit = t_last;
    if (mwel) begin
      a = addr % DEPTH;
      base = a - (a % PAGE);
      foreach (q[i]) mdl[base + ((a % PAGE) + i) % PAGE] = q[i];
      mwel = 1'b0;
    end
  endtask

  task automatic do_read(input int addr, input int n, input string tag);
    logic [7:0] d;
    sel_on();
    spi_byte(8'h03, d); spi_byte(addr[15:8], d); spi_byte(addr[7:0], d);
    for (int i = 0; i < n; i++) begin
      logic [7:0] exp;
      spi_byte(8'h00, d);
      exp = mdl[(addr + i) % DEPTH];
      chk(d === exp, tag, d, exp);
    end
    sel_off();
  endtask

  task automatic wait_ready(output int el);
    logic [7:0] s;
    int guard = 0;
    do begin
      rdsr(s);
      guard++;
    end while (s[0] && guard < 50);
    el = cyc - t_commit;
  endtask

  initial begin
    logic [7:0] s, d;
    int el;
    bit r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wclk(2);

    chk(!miso_oe, "R12 oe after reset", miso_oe, 0);
    chk_status(8'h00, "R12 R4 status after reset");

    cmd(8'h06); mwel = 1'b1;
    chk_status(8'h02, "R5 latch set");
    mode3 = 1'b1;
    chk_status(8'h02, "R1 mode 3 status read");
    mode3 = 1'b0;
    cmd(8'h04); mwel = 1'b0;
    chk_status(8'h00, "R6 latch clear by 0x04");

    // ninth clock after latch-set opcode
    sel_on(); spi_byte(8'h06, d); spi_bit(1'b0, r); sel_off();
    chk_status(8'h00, "R5 extra clock rejects latch set");

    // first page write and busy interval
    cmd(8'h06); mwel = 1'b1;
    do_write(16'h0005, '{8'hA0, 8'hA1, 8'hA2, 8'hA3});
    chk_status(8'h01, "R6 R11 latch cleared and busy after write");
    cmd(8'h06);
    sel_on(); spi_byte(8'h03, d); spi_byte(8'h00, d); spi_byte(8'h05, d); spi_byte(8'h00, d); sel_off();
    chk(!oe_seen, "R11 read blocked while busy", oe_seen, 0);
    wait_ready(el);
    chk(el >= WCYC && el <= WCYC + 400, "R11 busy duration", el, WCYC);
    chk_status(8'h00, "R11 latch set ignored while busy");

    do_read(16'h0005, 4, "R9 sequential read");
    mode3 = 1'b1;
    do_read(16'h0006, 2, "R1 mode 3 read");
    mode3 = 1'b0;

    // write with latch clear
    do_write(16'h0005, '{8'h55});
    chk_status(8'h00, "R7 no busy without latch");
    do_read(16'h0005, 1, "R7 array unchanged");

    // release mid-byte
    cmd(8'h06);
    sel_on();
    spi_byte(8'h02, d); spi_byte(8'h00, d); spi_byte(8'h05, d); spi_byte(8'h77, d);
    spi_bit(1'b1, r); spi_bit(1'b0, r); spi_bit(1'b1, r);
    sel_off();
    chk_status(8'h02, "R8 abort keeps latch and no busy");
    do_read(16'h0005, 1, "R8 abort keeps array");
    cmd(8'h04);

    // page wrap
    cmd(8'h06); mwel = 1'b1;
    do_write(16'h001E, '{8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB5, 8'hB6, 8'hB7});
    wait_ready(el);
    do_read(16'h0010, 6, "R10 wrapped bytes at page start");
    do_read(16'h001E, 2, "R10 bytes at page end");
    do_read(16'h0005, 4, "R10 other page untouched");

    // array top wrap and upper address bits
    cmd(8'h06); mwel = 1'b1;
    do_write(16'h003E, '{8'hC0, 8'hC1});
    wait_ready(el);
    cmd(8'h06); mwel = 1'b1;
    do_write(16'h0000, '{8'hD0});
    wait_ready(el);
    do_read(16'h003E, 3, "R9 wrap at top of array");
    do_read(16'h013E, 1, "R9 upper address bits dropped");

    // status write
    cmd(8'h06); mwel = 1'b1;
    sel_on(); spi_byte(8'h01, d); spi_byte(8'hAB, d); sel_off();
    t_commit = t_last; mwel = 1'b0; muser = 6'h2A;
    chk_status({muser, 1'b0, 1'b1}, "R4 R6 status write busy and latch cleared");
    wait_ready(el);
    chk_status({muser, 2'b00}, "R4 user bits written");
    sel_on(); spi_byte(8'h01, d); spi_byte(8'h00, d); sel_off();
    chk_status({muser, 2'b00}, "R7 status write without latch");

    // unknown opcode then valid-looking bytes
    sel_on(); spi_byte(8'hFF, d); spi_byte(8'h06, d); spi_byte(8'h05, d); spi_byte(8'h00, d); sel_off();
    chk(!oe_seen, "R3 unknown opcode drives nothing", oe_seen, 0);
    chk_status({muser, 2'b00}, "R3 unknown opcode changes nothing");

    wclk(10);
    summary();
  end
endmodule